// File: doc/BRIEF.md
# Display-ID Mode Controller with Recovery

This block decides which of two serial access styles an identification EEPROM is using. After reset the part streams its contents on a dedicated transmit clock (transmit-only). Activity on the two-wire bus clock pulls it out of that mode. The locking build then stays in bidirectional mode until reset. The recovering build first enters a transition state. It stays bidirectional only if the host proves it is present by sending a START followed by a matching device-select byte.

In the transition state the controller counts transmit-clock rising edges and system-clock cycles. If either limit runs out before a valid selection arrives, it falls back to transmit-only. Every falling edge of the bus clock restarts both counts. The controller also gates write permission. Writes are allowed only while the controller is not in transmit-only mode and the chosen enable source is high. That source is either the transmit-clock pin or a separate write-control pin. All bus and clock pins are sampled by the system clock. The memory datapath, acknowledge generation and the array lie outside this block.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (transmit-only) and `wr_permit_o` is 0. The encodings are 2'b00 transmit-only, 2'b01 transition, 2'b10 locked bidirectional, and 2'b11 never appears.
- R2: With RECOVER=1, the first falling edge of `scl_i` seen in transmit-only mode moves `mode_o` to 2'b01.
- R3: With RECOVER=0, the first falling edge of `scl_i` moves `mode_o` directly to 2'b10, and it stays there until reset.
- R4: A START (`sda_i` falls while `scl_i` is high) followed by eight bits sampled on `scl_i` rising edges, MSB first, is a device-select byte. Bits 7:4 must equal 4'b1010. With CE_ZERO=1, bits 3:1 must be 3'b000; with CE_ZERO=0 they are ignored. Bit 0 is ignored. A match seen while in transition moves `mode_o` to 2'b10.
- R5: In transition without a match, `mode_o` returns to 2'b00 on the TX_LIMIT-th (default 128) rising edge of `txclk_i`, or after TIMEOUT_CYC system-clock cycles, whichever comes first.
- R6: In transition, every falling edge of `scl_i` restarts both the transmit-clock edge count and the cycle timeout from zero.
- R7: In locked mode, `txclk_i` edges and elapsed time have no effect on `mode_o`.
- R8: `wr_permit_o` is 1 only when `mode_o` is not 2'b00 and the enable source is high. The source is `txclk_i` when WE_FROM_TXCLK=1, otherwise `wctl_i`. A low source (including an undriven write-control pin tied low by the board) means writes are blocked.
- R9: A STOP (`sda_i` rises while `scl_i` is high) or a new START before the eighth bit discards the partly received byte. Bits after a STOP count toward no byte, and a new START begins a fresh byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Two-wire bus clock level |
| sda_i | input | 1 | Two-wire bus data level |
| txclk_i | input | 1 | Transmit-only clock; also a write-enable source in one build |
| wctl_i | input | 1 | Separate write-control level, high permits writes |
| mode_o | output | 2 | Current mode: 00 transmit-only, 01 transition, 10 locked |
| wr_permit_o | output | 1 | Write instructions may execute |

## Verification
A wrong mode register appears directly on `mode_o` within three system-clock cycles of the bus edge that caused it. Two input sampling stages plus the state register make up that delay. A miscounted recovery counter is harder to see. It shows only as a fallback that comes one transmit pulse early or late, or that occurs after a bus-clock edge should have restarted the count. So the bench places its checks exactly at the 127th and 128th pulses. A decoder that misses an abort locks on a byte assembled across a STOP. That mismatch is visible at `mode_o` right after the eighth rising edge of the bus clock.

// File: rtl/ddc_mode_pkg.sv
package ddc_mode_pkg;
  typedef enum logic [1:0] {
    MODE_TXONLY = 2'b00,
    MODE_TRANS  = 2'b01,
    MODE_LOCKED = 2'b10
  } mode_e;

  localparam int unsigned SEL_BITS = 8;
  localparam logic [3:0]  SEL_FAMILY = 4'b1010;
endpackage

// File: rtl/ddc_line_sampler.sv
// Registers a group of asynchronous pin levels and flags their edges.
module ddc_line_sampler #(
  parameter int unsigned    N       = 4,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] cur_q;
  logic [N-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RST_VAL;
      prv_q <= RST_VAL;
    end else begin
      cur_q <= raw_i;
      prv_q <= cur_q;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise_o[g] = cur_q[g] & ~prv_q[g];
    assign fall_o[g] = ~cur_q[g] & prv_q[g];
  end

  assign lvl_o = cur_q;
endmodule

// File: rtl/ddc_dsel_decoder.sv
// Watches for START + device-select byte and pulses hit_o on a match.
module ddc_dsel_decoder
  import ddc_mode_pkg::*;
#(
  parameter bit CE_ZERO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(SEL_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(SEL_BITS - 1);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [SEL_BITS-1:0] sh_q, sh_n;
  logic          hit_q, hit_n;
  logic          bus_start, bus_stop;
  logic [SEL_BITS-1:0] byte_in;
  logic          byte_ok;

  assign bus_start = sda_fall & scl_lvl & ~scl_rise;
  assign bus_stop  = sda_rise & scl_lvl & ~scl_rise;
  assign byte_in   = {sh_q[SEL_BITS-2:0], sda_lvl};

  if (CE_ZERO) begin : g_ce_zero
    assign byte_ok = (byte_in[7:4] == SEL_FAMILY) && (byte_in[3:1] == 3'b000);
  end else begin : g_ce_any
    assign byte_ok = (byte_in[7:4] == SEL_FAMILY);
  end

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    hit_n = 1'b0;
    if (bus_start) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (bus_stop) begin
      act_n = 1'b0;
    end else if (act_q && scl_rise) begin
      sh_n = byte_in;
      if (cnt_q == LAST_BIT) begin
        act_n = 1'b0;
        hit_n = byte_ok;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      hit_q <= hit_n;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/ddc_recovery_timer.sv
// Counts transmit-clock edges and cycles while the transition state runs.
module ddc_recovery_timer #(
  parameter int unsigned TX_LIMIT    = 128,
  parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic tx_rise_i,
  output logic expire_o
);
  localparam int unsigned TXW = $clog2(TX_LIMIT + 1);
  localparam int unsigned TMW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TXW-1:0] TX_LAST = TXW'(TX_LIMIT - 1);
  localparam logic [TMW-1:0] TM_LAST = TMW'(TIMEOUT_CYC - 1);

  logic [TXW-1:0] tx_q, tx_n;
  logic [TMW-1:0] tm_q, tm_n;
  logic           cnt_en;

  assign cnt_en = run_i & ~clr_i;

  always_comb begin
    tx_n = '0;
    tm_n = '0;
    if (cnt_en) begin
      tx_n = tx_rise_i ? tx_q + 1'b1 : tx_q;
      tm_n = tm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      tm_q <= '0;
    end else begin
      tx_q <= tx_n;
      tm_q <= tm_n;
    end
  end

  assign expire_o = cnt_en & ((tx_rise_i && tx_q == TX_LAST) || (tm_q == TM_LAST));
endmodule

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl
  import ddc_mode_pkg::*;
#(
  parameter bit          RECOVER       = 1'b1,
  parameter bit          CE_ZERO       = 1'b0,
  parameter bit          WE_FROM_TXCLK = 1'b0,
  parameter int unsigned TX_LIMIT      = 128,
  parameter int unsigned TIMEOUT_CYC   = 200_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       txclk_i,
  input  logic       wctl_i,
  output logic [1:0] mode_o,
  output logic       wr_permit_o
);
  localparam int unsigned PINS = 4;
  localparam int unsigned P_SCL = 0;
  localparam int unsigned P_SDA = 1;
  localparam int unsigned P_TX  = 2;
  localparam int unsigned P_WC  = 3;

  // reset synchronizer: assert asynchronously, release on clk
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [PINS-1:0] lvl, rise, fall;
  ddc_line_sampler #(.N(PINS), .RST_VAL(4'b0011)) u_smp (
    .clk(clk), .rst_n(rst_s_n),
    .raw_i({wctl_i, txclk_i, sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic scl_fall;
  logic sel_hit;
  logic rec_expire;
  mode_e mode_q, mode_n;
  mode_e leave_to;

  assign scl_fall = fall[P_SCL];

  ddc_dsel_decoder #(.CE_ZERO(CE_ZERO)) u_dec (
    .clk(clk), .rst_n(rst_s_n),
    .scl_lvl(lvl[P_SCL]), .scl_rise(rise[P_SCL]),
    .sda_lvl(lvl[P_SDA]), .sda_rise(rise[P_SDA]), .sda_fall(fall[P_SDA]),
    .hit_o(sel_hit)
  );

  ddc_recovery_timer #(.TX_LIMIT(TX_LIMIT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_s_n),
    .run_i(mode_q == MODE_TRANS),
    .clr_i(scl_fall),
    .tx_rise_i(rise[P_TX]),
    .expire_o(rec_expire)
  );

  if (RECOVER) begin : g_recover
    assign leave_to = MODE_TRANS;
  end else begin : g_lock
    assign leave_to = MODE_LOCKED;
  end

  always_comb begin
    mode_n = mode_q;
    unique case (mode_q)
      MODE_TXONLY: if (scl_fall) mode_n = leave_to;
      MODE_TRANS: begin
        if (sel_hit)         mode_n = MODE_LOCKED;
        else if (scl_fall)   mode_n = MODE_TRANS;
        else if (rec_expire) mode_n = MODE_TXONLY;
      end
      MODE_LOCKED: mode_n = MODE_LOCKED;
      default:     mode_n = MODE_TXONLY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) mode_q <= MODE_TXONLY;
    else          mode_q <= mode_n;
  end

  logic we_src;
  if (WE_FROM_TXCLK) begin : g_we_tx
    assign we_src = lvl[P_TX];
  end else begin : g_we_pin
    assign we_src = lvl[P_WC];
  end

  assign mode_o      = mode_q;
  assign wr_permit_o = (mode_q != MODE_TXONLY) & we_src;
endmodule

// File: rtl/ddc_mode_ctrl_chk.sv
module ddc_mode_ctrl_chk
  import ddc_mode_pkg::*;
#(
  parameter bit RECOVER = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       wr_permit,
  input logic       scl_fall,
  input logic       sel_hit,
  input logic       rec_expire
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_first_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (RECOVER && mode == MODE_TXONLY && scl_fall) |=> (mode == MODE_TRANS));

  p_direct_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!RECOVER && mode == MODE_TXONLY && scl_fall) |=> (mode == MODE_LOCKED));

  p_hit_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRANS && sel_hit) |=> (mode == MODE_LOCKED));

  p_no_early_revert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRANS && !rec_expire) |=> (mode != MODE_TXONLY));

  p_fall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRANS && scl_fall) |=> (mode != MODE_TXONLY));

  p_locked_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOCKED) |=> (mode == MODE_LOCKED));

  p_permit_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TXONLY) |-> !wr_permit);
endmodule

bind ddc_mode_ctrl ddc_mode_ctrl_chk #(.RECOVER(RECOVER)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .mode(mode_q), .wr_permit(wr_permit_o),
  .scl_fall(scl_fall), .sel_hit(sel_hit), .rec_expire(rec_expire)
);

// File: tb/ddc_mode_ctrl_tb_top.sv
module ddc_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n, scl, sda, txclk, wctl;
  logic [1:0] m_rec, m_lock, m_ce;
  logic       wp_rec, wp_lock, wp_ce;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddc_mode_ctrl #(.RECOVER(1'b1), .CE_ZERO(1'b1), .WE_FROM_TXCLK(1'b0),
                  .TX_LIMIT(128), .TIMEOUT_CYC(2000)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .txclk_i(txclk),
    .wctl_i(wctl), .mode_o(m_rec), .wr_permit_o(wp_rec));

  ddc_mode_ctrl #(.RECOVER(1'b0), .CE_ZERO(1'b0), .WE_FROM_TXCLK(1'b1),
                  .TX_LIMIT(128), .TIMEOUT_CYC(2000)) dut_lock_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .txclk_i(txclk),
    .wctl_i(wctl), .mode_o(m_lock), .wr_permit_o(wp_lock));

  ddc_mode_ctrl #(.RECOVER(1'b1), .CE_ZERO(1'b0), .WE_FROM_TXCLK(1'b0),
                  .TX_LIMIT(128), .TIMEOUT_CYC(2000)) dut_ce_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .txclk_i(txclk),
    .wctl_i(wctl), .mode_o(m_ce), .wr_permit_o(wp_ce));

  // {select byte, locks when CE must be zero, locks when CE ignored}
  localparam logic [9:0] VEC [8] = '{
    {8'hA0, 1'b1, 1'b1}, {8'hA1, 1'b1, 1'b1}, {8'hA2, 1'b0, 1'b1},
    {8'hAE, 1'b0, 1'b1}, {8'hAF, 1'b0, 1'b1}, {8'hB0, 1'b0, 1'b0},
    {8'h20, 1'b0, 1'b0}, {8'hE0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; txclk = 1'b0; wctl = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic bus_start();
    sda = 1'b1; cyc(2); scl = 1'b1; cyc(2); sda = 1'b0; cyc(2); scl = 1'b0; cyc(2);
  endtask

  task automatic bus_stop();
    sda = 1'b0; cyc(2); scl = 1'b1; cyc(2); sda = 1'b1; cyc(2);
  endtask

  task automatic send_bit(input logic v);
    sda = v; cyc(2); scl = 1'b1; cyc(2); scl = 1'b0; cyc(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic scl_pulse();
    scl = 1'b1; cyc(2); scl = 1'b0; cyc(3);
  endtask

  task automatic tx_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      txclk = 1'b1; cyc(2); txclk = 1'b0; cyc(2);
    end
    cyc(3);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 mode rec", m_rec, 2'b00);
    check("R1 mode lock", m_lock, 2'b00);
    check("R1 permit", wp_rec, 1'b0);

    // table of select bytes
    for (int k = 0; k < 8; k++) begin
      do_reset();
      bus_start();
      check("R2 enter transition", m_rec, 2'b01);
      check("R3 direct lock", m_lock, 2'b10);
      send_byte(VEC[k][9:2]);
      cyc(4);
      check("R4 select CE zero", m_rec, VEC[k][1] ? 2'b10 : 2'b01);
      check("R4 select CE any", m_ce, VEC[k][0] ? 2'b10 : 2'b01);
    end

    // R7: locked ignores transmit clock and time (dut_i locked on A1 above? redo)
    do_reset();
    bus_start(); send_byte(8'hA0); cyc(4);
    tx_pulses(200); cyc(2500);
    check("R7 locked sticky", m_rec, 2'b10);
    check("R3 lock held", m_lock, 2'b10);

    // R5: 127 pulses keep transition, 128th reverts
    do_reset();
    scl_pulse();
    check("R2 scl fall", m_rec, 2'b01);
    tx_pulses(127);
    check("R5 127 pulses", m_rec, 2'b01);
    tx_pulses(1);
    check("R5 128th pulse", m_rec, 2'b00);

    // R6: scl fall restarts the pulse count
    do_reset();
    scl_pulse();
    tx_pulses(100);
    scl_pulse();
    tx_pulses(100);
    check("R6 after restart", m_rec, 2'b01);
    tx_pulses(27);
    check("R6 127 since restart", m_rec, 2'b01);
    tx_pulses(1);
    check("R6 128 since restart", m_rec, 2'b00);

    // R5: cycle timeout, R6: restart of timer
    do_reset();
    scl_pulse();
    cyc(1900);
    check("R5 before timeout", m_rec, 2'b01);
    scl_pulse();
    cyc(1900);
    check("R6 timer restarted", m_rec, 2'b01);
    cyc(200);
    check("R5 timeout revert", m_rec, 2'b00);

    // R9: STOP mid-byte discards bits
    do_reset();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    scl = 1'b0; cyc(2);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    cyc(4);
    check("R9 stop abort", m_rec, 2'b01);

    // R9: repeated START restarts the byte
    do_reset();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'h0A);
    cyc(4);
    check("R9 restart abort", m_rec, 2'b01);

    // R8: write permission
    do_reset();
    wctl = 1'b1; cyc(4);
    check("R8 txonly blocks", wp_rec, 1'b0);
    scl_pulse();
    check("R8 transition permits", wp_rec, 1'b1);
    wctl = 1'b0; cyc(4);
    check("R8 pin low blocks", wp_rec, 1'b0);
    txclk = 1'b1; cyc(4);
    check("R8 txclk source high", wp_lock, 1'b1);
    txclk = 1'b0; cyc(4);
    check("R8 txclk source low", wp_lock, 1'b0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule